// File: doc/BRIEF.md
# AXI4 Write Beat-Spacing Shim

This block sits in the write path between an AXI4 master and an AXI4 slave. It covers the write address, write data and write response channels. Every address field, data word, strobe, last flag and response passes straight through. Only the handshakes are gated. After each write data beat that the slave accepts, the shim holds the data channel idle for a fixed number of cycles, 15 by default. This gives logic beside the slave time to act on each beat before the next one arrives. The shim also allows only one write transaction to be open at a time. A transaction opens on the address handshake and closes on the response handshake.

Every channel follows valid/ready rules on both sides. Back-pressure from the slave reaches the master unchanged, except where the shim adds its own hold. The master may raise WVALID before, together with, or after its address handshake. Any data the master offers before its address is accepted waits at the shim and is never shown to the slave. Address acceptance depends only on the slave's AWREADY and on whether a write is already open. It never depends on activity on the data channel, so the shim cannot deadlock with a master that waits for WREADY before it presents an address.

Top module: `wr_beat_gap_shim`

## Requirements
- R1: After reset no write is open. `up_awready` equals `dn_awready`, and `dn_wvalid` and `up_wready` stay low even while `up_wvalid` and `dn_wready` are high.
- R2: A write is open from its address handshake until its response handshake. While a write is open, `dn_awvalid` and `up_awready` are low, so no second address handshake happens.
- R3: The cycle after a response handshake, a waiting address with `dn_awready` high completes its handshake. There are no extra idle cycles.
- R4: No data beat reaches the slave unless a write is open. The first beat completes no earlier than 2 cycles after its address handshake. With WVALID already high and the slave ready, it completes exactly 2 cycles after.
- R5: After each accepted data beat, `dn_wvalid` and `up_wready` stay low for the next GAP_CYCLES cycles (15 by default). Consecutive beats are therefore at least 16 cycles apart, and exactly 16 apart when both sides stay ready.
- R6: In every cycle, a data handshake on the slave side happens if and only if one happens on the master side. No beat is lost or duplicated.
- R7: The address fields (id, addr, len, size, burst) and the data fields (data, strobe, last) on the slave side equal their master-side inputs in every cycle.
- R8: The response valid, ready, id and resp fields pass through unchanged, and each address handshake is matched by exactly one response handshake.
- R9: An address is accepted with no data-channel activity at all, in the same cycle that `up_awvalid` and `dn_awready` are both high and no write is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_awvalid | input | 1 | Master address valid |
| up_awready | output | 1 | Address ready to master |
| up_awid | input | ID_W | Master address id |
| up_awaddr | input | ADDR_W | Master address |
| up_awlen | input | 8 | Master burst length minus one |
| up_awsize | input | 3 | Master beat size |
| up_awburst | input | 2 | Master burst type |
| up_wvalid | input | 1 | Master data valid |
| up_wready | output | 1 | Data ready to master |
| up_wdata | input | DATA_W | Master write data |
| up_wstrb | input | DATA_W/8 | Master byte strobes |
| up_wlast | input | 1 | Master last beat |
| up_bvalid | output | 1 | Response valid to master |
| up_bready | input | 1 | Master response ready |
| up_bid | output | ID_W | Response id to master |
| up_bresp | output | 2 | Response code to master |
| dn_awvalid | output | 1 | Address valid to slave |
| dn_awready | input | 1 | Slave address ready |
| dn_awid | output | ID_W | Address id to slave |
| dn_awaddr | output | ADDR_W | Address to slave |
| dn_awlen | output | 8 | Burst length to slave |
| dn_awsize | output | 3 | Beat size to slave |
| dn_awburst | output | 2 | Burst type to slave |
| dn_wvalid | output | 1 | Data valid to slave |
| dn_wready | input | 1 | Slave data ready |
| dn_wdata | output | DATA_W | Write data to slave |
| dn_wstrb | output | DATA_W/8 | Byte strobes to slave |
| dn_wlast | output | 1 | Last beat to slave |
| dn_bvalid | input | 1 | Slave response valid |
| dn_bready | output | 1 | Response ready to slave |
| dn_bid | input | ID_W | Slave response id |
| dn_bresp | input | 2 | Slave response code |

## Verification
A stuck open-write flag shows at the ports within one cycle. If it is stuck high, addresses stall for good. If it is stuck low, a second address is accepted, and the bench flags this at that handshake. A first-beat hold that clears too early lets a beat reach the slave before its address. A hold that never clears leaves the data channel frozen until the watchdog fires. A wrong gap counter load shows up on the next beat, as spacing other than 16 cycles. A lost or doubled beat shows at once as a mismatch between the handshakes on the two sides, or as a wrong data word at the slave.

// File: rtl/wbg_pkg.sv
package wbg_pkg;
  // fixed AXI4 field widths used by the shim
  localparam int unsigned LEN_W   = 8;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned RESP_W  = 2;

  // width needed to hold a count of n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wbg_addr_track.sv
module wbg_addr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic up_awvalid,
  input  logic dn_awready,
  input  logic b_hs,
  output logic up_awready,
  output logic dn_awvalid,
  output logic aw_hs,
  output logic busy
);
  // address channel is only offered while nothing is open
  assign dn_awvalid = up_awvalid & ~busy;
  assign up_awready = dn_awready & ~busy;
  assign aw_hs      = up_awvalid & dn_awready & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n)     busy <= 1'b0;
    else if (aw_hs) busy <= 1'b1;
    else if (b_hs)  busy <= 1'b0;
  end

  // R2: an accepted address opens the write
  a_r2_open_after_aw: assert property (@(posedge clk) disable iff (!rst_n)
    aw_hs |=> busy);
  // R3: a response handshake closes the write
  a_r3_close_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && b_hs) |=> !busy);
endmodule

// File: rtl/wbg_first_beat.sv
module wbg_first_beat (
  input  logic clk,
  input  logic rst_n,
  input  logic aw_hs,
  input  logic b_hs,
  input  logic busy,
  input  logic up_wvalid,
  output logic hold
);
  // armed out of reset and at every transaction boundary; released once
  // the address is held and the master is offering its first beat
  always_ff @(posedge clk) begin
    if (!rst_n)                hold <= 1'b1;
    else if (aw_hs || b_hs)    hold <= 1'b1;
    else if (busy && up_wvalid) hold <= 1'b0;
  end

  // R4: re-armed after each boundary handshake
  a_r4_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_hs || b_hs) |=> hold);
endmodule

// File: rtl/wbg_gap_timer.sv
module wbg_gap_timer #(
  parameter int unsigned GAP_CYCLES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_hs,
  output logic gap_on
);
  localparam int unsigned CNT_W = wbg_pkg::cnt_width(GAP_CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(GAP_CYCLES);

  generate
    if (GAP_CYCLES == 0) begin : g_nogap
      logic unused_beat;
      assign unused_beat = beat_hs;
      assign gap_on = 1'b0;
    end else begin : g_gap
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (beat_hs)      cnt <= LOAD;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
      end
      assign gap_on = (cnt != '0);

      // R5: each accepted beat starts a gap
      a_r5_gap_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_hs |=> gap_on);
      // R5: no beat is accepted during a gap, so it counts down undisturbed
      a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    end
  endgenerate
endmodule

// File: rtl/wr_beat_gap_shim.sv
module wr_beat_gap_shim #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned GAP_CYCLES = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        up_awvalid,
  output logic                        up_awready,
  input  logic [ID_W-1:0]             up_awid,
  input  logic [ADDR_W-1:0]           up_awaddr,
  input  logic [wbg_pkg::LEN_W-1:0]   up_awlen,
  input  logic [wbg_pkg::SIZE_W-1:0]  up_awsize,
  input  logic [wbg_pkg::BURST_W-1:0] up_awburst,
  input  logic                        up_wvalid,
  output logic                        up_wready,
  input  logic [DATA_W-1:0]           up_wdata,
  input  logic [DATA_W/8-1:0]         up_wstrb,
  input  logic                        up_wlast,
  output logic                        up_bvalid,
  input  logic                        up_bready,
  output logic [ID_W-1:0]             up_bid,
  output logic [wbg_pkg::RESP_W-1:0]  up_bresp,
  output logic                        dn_awvalid,
  input  logic                        dn_awready,
  output logic [ID_W-1:0]             dn_awid,
  output logic [ADDR_W-1:0]           dn_awaddr,
  output logic [wbg_pkg::LEN_W-1:0]   dn_awlen,
  output logic [wbg_pkg::SIZE_W-1:0]  dn_awsize,
  output logic [wbg_pkg::BURST_W-1:0] dn_awburst,
  output logic                        dn_wvalid,
  input  logic                        dn_wready,
  output logic [DATA_W-1:0]           dn_wdata,
  output logic [DATA_W/8-1:0]         dn_wstrb,
  output logic                        dn_wlast,
  input  logic                        dn_bvalid,
  output logic                        dn_bready,
  input  logic [ID_W-1:0]             dn_bid,
  input  logic [wbg_pkg::RESP_W-1:0]  dn_bresp
);
  logic aw_hs, busy, b_hs, hold, gap_on, w_pass, beat_hs;

  // payloads pass untouched
  assign dn_awid    = up_awid;
  assign dn_awaddr  = up_awaddr;
  assign dn_awlen   = up_awlen;
  assign dn_awsize  = up_awsize;
  assign dn_awburst = up_awburst;
  assign dn_wdata   = up_wdata;
  assign dn_wstrb   = up_wstrb;
  assign dn_wlast   = up_wlast;
  assign up_bvalid  = dn_bvalid;
  assign dn_bready  = up_bready;
  assign up_bid     = dn_bid;
  assign up_bresp   = dn_bresp;

  assign b_hs = dn_bvalid & up_bready;

  wbg_addr_track u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_awvalid (up_awvalid),
    .dn_awready (dn_awready),
    .b_hs       (b_hs),
    .up_awready (up_awready),
    .dn_awvalid (dn_awvalid),
    .aw_hs      (aw_hs),
    .busy       (busy)
  );

  wbg_first_beat u_first (
    .clk       (clk),
    .rst_n     (rst_n),
    .aw_hs     (aw_hs),
    .b_hs      (b_hs),
    .busy      (busy),
    .up_wvalid (up_wvalid),
    .hold      (hold)
  );

  wbg_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_hs (beat_hs),
    .gap_on  (gap_on)
  );

  // both sides of the data channel are gated by the same term, so a beat
  // moves on the slave side exactly when it moves on the master side
  assign w_pass    = ~hold & ~gap_on;
  assign dn_wvalid = up_wvalid & w_pass;
  assign up_wready = dn_wready & w_pass;
  assign beat_hs   = dn_wvalid & dn_wready;

  // R4: the first-beat hold is always armed while no write is open
  a_r4_armed_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> hold);
  // R4: no beat reaches the slave outside an open write
  a_r4_no_beat_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(dn_wvalid && dn_wready));
  // R8: responses only close an open write
  a_r8_b_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    (up_bvalid && up_bready) |-> busy);
endmodule

// File: tb/wr_beat_gap_shim_bench.sv
module wr_beat_gap_shim_bench;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int ID_W   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n = 1'b0;

  logic up_awvalid = 0, up_awready;
  logic [ID_W-1:0] up_awid = '0;
  logic [ADDR_W-1:0] up_awaddr = '0;
  logic [7:0] up_awlen = '0;
  logic [2:0] up_awsize = 3'd3;
  logic [1:0] up_awburst = 2'd1;
  logic up_wvalid = 0, up_wready;
  logic [DATA_W-1:0] up_wdata = '0;
  logic [DATA_W/8-1:0] up_wstrb = '0;
  logic up_wlast = 0;
  logic up_bvalid, up_bready = 1;
  logic [ID_W-1:0] up_bid;
  logic [1:0] up_bresp;
  logic dn_awvalid, dn_awready = 1;
  logic [ID_W-1:0] dn_awid;
  logic [ADDR_W-1:0] dn_awaddr;
  logic [7:0] dn_awlen;
  logic [2:0] dn_awsize;
  logic [1:0] dn_awburst;
  logic dn_wvalid, dn_wready = 1;
  logic [DATA_W-1:0] dn_wdata;
  logic [DATA_W/8-1:0] dn_wstrb;
  logic dn_wlast;
  logic dn_bvalid = 0, dn_bready;
  logic [ID_W-1:0] dn_bid = '0;
  logic [1:0] dn_bresp = '0;

  wr_beat_gap_shim u_wr_beat_gap_shim (.*);

  int vec = 0, bad = 0, cyc = 0;
  int aw_cnt = 0, b_cnt = 0, w_cnt = 0, lasts_seen = 0;
  int last_aw = -100, last_b = -100, last_w = -1000, first_w = -1000, beat_idx = 0;
  bit open = 0;
  bit wr_toggle = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DATA_W-1:0] beat_word(input int txn, input int b);
    return {32'hC0DE_0000 + 32'(txn), 32'(b)};
  endfunction

  // port monitor: sampled half a cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit uh, dh;
      cyc++;
      if (up_bvalid && up_bready) begin
        chk(up_bid == dn_bid && up_bresp == dn_bresp, "R8", up_bresp, dn_bresp);
        b_cnt++; last_b = cyc; open = 0;
      end
      if (dn_awvalid && dn_awready) begin
        chk(!open, "R2", open, 0);
        chk(dn_awaddr == up_awaddr && dn_awid == up_awid && dn_awlen == up_awlen &&
            dn_awsize == up_awsize && dn_awburst == up_awburst, "R7", dn_awaddr, up_awaddr);
        open = 1; aw_cnt++; last_aw = cyc; beat_idx = 0;
      end
      uh = up_wvalid && up_wready;
      dh = dn_wvalid && dn_wready;
      if (uh || dh) chk(uh == dh, "R6", dh, uh);
      if (dh) begin
        chk(open, "R4", open, 1);
        if (beat_idx == 0) first_w = cyc;
        else chk(cyc - last_w >= 16, "R5", cyc - last_w, 16);
        chk(dn_wdata == beat_word(aw_cnt, beat_idx) && dn_wstrb == up_wstrb &&
            dn_wlast == up_wlast, "R7", dn_wdata, beat_word(aw_cnt, beat_idx));
        last_w = cyc; beat_idx++; w_cnt++;
        if (dn_wlast) lasts_seen++;
      end
    end
  end

  // slave model
  initial begin
    int served = 0, b_served = 0, bwait = 2;
    forever begin
      @(posedge clk); #1;
      dn_wready = wr_toggle ? (cyc % 2 == 0) : 1'b1;
      if (dn_bvalid && b_cnt > b_served) begin
        dn_bvalid = 0; b_served++;
      end else if (lasts_seen > served && !dn_bvalid) begin
        if (bwait == 0) begin
          dn_bvalid = 1; dn_bid = ID_W'(served); dn_bresp = (served % 2 == 0) ? 2'b00 : 2'b10;
          served++; bwait = 2;
        end else bwait--;
      end
    end
  end

  task automatic send_aw(input int txn, input int len);
    up_awvalid = 1; up_awaddr = ADDR_W'(32'h1000 * txn); up_awlen = 8'(len);
    up_awid = ID_W'(txn); up_awsize = 3'(txn % 4); up_awburst = 2'd1;
    do @(negedge clk); while (!(up_awvalid && up_awready));
    @(posedge clk); #1;
    up_awvalid = 0;
  endtask

  task automatic send_w(input int txn, input int len);
    for (int b = 0; b <= len; b++) begin
      up_wvalid = 1; up_wdata = beat_word(txn, b); up_wlast = (b == len);
      up_wstrb = DATA_W/8'(8'hF0 >> (b % 4));
      do @(negedge clk); while (!(up_wvalid && up_wready));
      @(posedge clk); #1;
    end
    up_wvalid = 0; up_wlast = 0;
  endtask

  task automatic wait_b(input int target);
    while (b_cnt < target) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // R1: reset state with data offered and slave ready
  task automatic t_reset;
    up_wvalid = 1; dn_wready = 1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (6) @(negedge clk);
    chk(up_awready == dn_awready, "R1", up_awready, dn_awready);
    chk(dn_wvalid == 0, "R1", dn_wvalid, 0);
    chk(up_wready == 0, "R4", up_wready, 0);
    chk(w_cnt == 0, "R1", w_cnt, 0);
    @(posedge clk); #1 up_wvalid = 0;
  endtask

  // mode 0: data first, 1: together, 2: address first
  task automatic t_write(input int len, input int mode);
    int txn = aw_cnt + 1;
    int b0 = b_cnt, w0 = w_cnt;
    if (mode == 0) begin
      fork
        send_w(txn, len);
        begin repeat (3) @(posedge clk); #1; send_aw(txn, len); end
      join
    end else if (mode == 1) begin
      fork send_w(txn, len); send_aw(txn, len); join
    end else begin
      send_aw(txn, len);
      repeat (3) @(posedge clk); #1;
      send_w(txn, len);
    end
    wait_b(b0 + 1);
    chk(b_cnt == b0 + 1 && aw_cnt == txn, "R8", b_cnt - b0, 1);
    chk(w_cnt - w0 == len + 1, "R6", w_cnt - w0, len + 1);
    if (!wr_toggle) begin
      if (mode != 2) chk(first_w == last_aw + 2, "R4", first_w - last_aw, 2);
      else chk(first_w > last_aw + 1, "R4", first_w - last_aw, 2);
      if (mode != 2) chk(last_w - first_w == 16 * len, "R5", last_w - first_w, 16 * len);
    end
    repeat (20) @(posedge clk); #1;
  endtask

  // R9: address alone is accepted at once
  task automatic t_aw_alone;
    int txn = aw_cnt + 1;
    int b0 = b_cnt;
    int start = cyc;
    send_aw(txn, 0);
    chk(last_aw - start <= 1, "R9", last_aw - start, 1);
    repeat (10) @(posedge clk); #1;
    send_w(txn, 0);
    wait_b(b0 + 1);
    chk(b_cnt == b0 + 1, "R8", b_cnt - b0, 1);
    repeat (5) @(posedge clk); #1;
  endtask

  // R2/R3: second address waits for the first response
  task automatic t_back_to_back;
    int t1 = aw_cnt + 1;
    int b0 = b_cnt;
    int bc = 0;
    fork
      begin send_aw(t1, 1); send_w(t1, 1); end
      begin
        while (aw_cnt < t1) @(negedge clk);
        @(posedge clk); #1;
        send_aw(t1 + 1, 0);
      end
      begin
        wait_b(b0 + 1);
        bc = last_b;
      end
    join
    chk(last_aw == bc + 1, "R3", last_aw - bc, 1);
    send_w(t1 + 1, 0);
    wait_b(b0 + 2);
    chk(b_cnt == b0 + 2 && aw_cnt == t1 + 1, "R2", b_cnt - b0, 2);
    repeat (5) @(posedge clk); #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_write(0, 0);
    t_write(3, 0);
    t_write(0, 1);
    t_write(4, 1);
    t_write(0, 2);
    t_write(2, 2);
    t_aw_alone();
    t_back_to_back();
    wr_toggle = 1;
    t_write(3, 1);
    t_write(2, 0);
    wr_toggle = 0;
    t_write(1, 1);
    finish_run();
  end
endmodule